// File: doc/BRIEF.md
# Double to Single Precision Narrowing Converter

This block narrows a 64-bit IEEE 754 binary64 value to a 32-bit binary32 value. The rounding direction is chosen per operation. Each result comes with four exception flags. The block is a two-stage pipeline that accepts one operand per clock cycle. A valid bit travels alongside the data.

The first stage splits the operand into sign, exponent and fraction. It resolves infinities and NaNs directly. For finite operands, it squeezes the fraction into a 32-bit working significand whose lowest bit is sticky, restores the implicit one, and rebiases the exponent. The second stage rounds, detects overflow and tininess, and packs the result.

Top module: `f64_to_f32_cvt`

## Requirements
- R1: An operand with an all-ones exponent and a nonzero fraction gives a quiet NaN built as follows: the operand sign in bit 31, 0xFF in bits 30..23, a 1 in bit 22, and operand fraction bits 50..29 in result bits 21..0.
- R2: `out_flags` bit 3 is invalid, bit 2 overflow, bit 1 underflow and bit 0 inexact. Invalid is raised only for a signaling NaN, which is an all-ones exponent with operand bit 51 clear and a nonzero fraction. A quiet NaN raises no flag.
- R3: An all-ones exponent with a zero fraction gives an infinity of the same sign (0x7F800000 or 0xFF800000) with no flags.
- R4: A finite operand whose value lies in the normal binary32 range rounds its 53-bit significand to 24 bits. In `rnd_mode` 0 this is to nearest with ties to even. A carry out of the significand increments the exponent.
- R5: `rnd_mode` encodes 0 = nearest-even, 1 = toward zero, 2 = toward minus infinity, 3 = toward plus infinity.
- R6: A result beyond the largest finite magnitude raises overflow and inexact. It becomes a signed infinity in mode 0 and in the directed mode pointing away from zero. In the other modes it becomes the signed largest finite value (magnitude 0x7F7FFFFF).
- R7: A value below the smallest normal magnitude, judged before rounding, is rounded to a subnormal result. Underflow is raised only when that result is inexact. An exact subnormal raises no flag.
- R8: A binary64 zero gives a zero of the same sign with no flags. A nonzero binary64 subnormal gives a signed zero, or the signed smallest subnormal (magnitude 1) under the directed mode away from zero, with underflow and inexact.
- R9: Inexact is set exactly when the rounded finite result differs from the operand value.
- R10: A result appears on `out_vld`/`out_flt`/`out_flags` two clock edges after its operand is taken with `in_vld`. Synchronous active-high `rst` clears both valid stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operand valid |
| in_dbl | input | 64 | binary64 operand |
| rnd_mode | input | 2 | Rounding direction (R5) |
| out_vld | output | 1 | Result valid |
| out_flt | output | 32 | binary32 result |
| out_flags | output | 4 | {invalid, overflow, underflow, inexact} |

## Verification
The checker relies on `rnd_mode` being one of the four listed codes, which holds since all 2-bit values are defined. It also relies on `in_vld` being held low during reset, so that the two-cycle valid relation holds from the first edge after reset. The random stimulus draws the exponent mostly from bands around the subnormal boundary, the overflow edge, zero and the all-ones code. It forces some fractions onto exact halfway and all-ones patterns so that ties and rounding carries occur often. All four modes are used, and a reset is applied with operands in flight.

// File: rtl/f2s_pkg.sv
`timescale 1ns/1ps
package f2s_pkg;
   typedef enum logic [1:0] {
      RM_NEAR_EVEN = 2'd0,
      RM_TO_ZERO   = 2'd1,
      RM_DOWN      = 2'd2,
      RM_UP        = 2'd3
   } rmode_e;

   typedef struct packed {
      logic invalid;
      logic overflow;
      logic underflow;
      logic inexact;
   } flags_t;
endpackage

// File: rtl/f2s_unpack.sv
`timescale 1ns/1ps
// Stage one: field split, special-value decode, significand compression.
module f2s_unpack #(
   parameter int DEXP_W  = 11,
   parameter int DFRAC_W = 52,
   parameter int SEXP_W  = 8,
   parameter int SFRAC_W = 23,
   parameter int GRD_W   = 7
) (
   input  logic [DEXP_W+DFRAC_W:0]        in_word,
   output logic                           sign,
   output logic                           is_special,
   output logic [SEXP_W+SFRAC_W:0]        special_word,
   output logic                           is_snan,
   output logic signed [DEXP_W+1:0]       zexp,
   output logic [SFRAC_W+GRD_W+1:0]       zsig
);
   localparam int DW     = 1 + DEXP_W + DFRAC_W;
   localparam int SIG_W  = SFRAC_W + GRD_W + 2;
   localparam int KEEP_W = SIG_W - 2;
   localparam int SHIFT  = DFRAC_W - KEEP_W;
   localparam int ZE_W   = DEXP_W + 2;
   localparam int DBIAS  = (1 << (DEXP_W - 1)) - 1;
   localparam int SBIAS  = (1 << (SEXP_W - 1)) - 1;
   localparam int REBIAS = DBIAS - SBIAS + 1;

   logic [DEXP_W-1:0]  ex;
   logic [DFRAC_W-1:0] fr;
   logic [KEEP_W-1:0]  kept;
   logic               sticky;
   logic               fr_nz;

   assign sign  = in_word[DW-1];
   assign ex    = in_word[DW-2 -: DEXP_W];
   assign fr    = in_word[DFRAC_W-1:0];
   assign fr_nz = |fr;

   generate
      if (SHIFT > 0) begin : g_compress
         assign kept   = fr[DFRAC_W-1:SHIFT];
         assign sticky = |fr[SHIFT-1:0];
      end else begin : g_widen
         assign kept   = KEEP_W'(fr) << (KEEP_W - DFRAC_W);
         assign sticky = 1'b0;
      end
   endgenerate

   assign is_special = &ex;
   assign is_snan    = is_special & fr_nz & ~fr[DFRAC_W-1];

   always_comb begin
      if (fr_nz)
         special_word = {sign, {SEXP_W{1'b1}}, 1'b1, fr[DFRAC_W-2 -: SFRAC_W-1]};
      else
         special_word = {sign, {SEXP_W{1'b1}}, {SFRAC_W{1'b0}}};
   end

   assign zsig = {1'b0, |ex, kept[KEEP_W-1:1], kept[0] | sticky};
   assign zexp = ZE_W'({2'b00, ex}) - ZE_W'(REBIAS);
endmodule

// File: rtl/f2s_round.sv
`timescale 1ns/1ps
// Stage two: rounding increment, overflow/tininess handling, packing.
module f2s_round
   import f2s_pkg::*;
#(
   parameter int SEXP_W  = 8,
   parameter int SFRAC_W = 23,
   parameter int GRD_W   = 7,
   parameter int ZE_W    = 13
) (
   input  logic                          sign,
   input  rmode_e                        mode,
   input  logic signed [ZE_W-1:0]        zexp,
   input  logic [SFRAC_W+GRD_W+1:0]      zsig,
   output logic [SEXP_W+SFRAC_W:0]       word,
   output logic                          ovf,
   output logic                          unf,
   output logic                          inx
);
   localparam int SIG_W = SFRAC_W + GRD_W + 2;
   localparam int SW    = 1 + SEXP_W + SFRAC_W;
   localparam int M_W   = SIG_W - GRD_W;
   localparam int OVF_E = (1 << SEXP_W) - 3;
   localparam logic [GRD_W-1:0] HALF = GRD_W'(1) << (GRD_W - 1);

   logic [GRD_W-1:0]  inc;
   logic              tiny;
   logic [ZE_W-1:0]   shamt;
   logic [SIG_W-1:0]  jsig;
   logic [SIG_W-1:0]  rsig;
   logic [SEXP_W-1:0] rexp;
   logic [SEXP_W-1:0] efin;
   logic [GRD_W-1:0]  rbits;
   logic [M_W-1:0]    m;
   logic              at_edge_carry;

   always_comb begin
      unique case (mode)
         RM_NEAR_EVEN: inc = HALF;
         RM_TO_ZERO:   inc = '0;
         RM_DOWN:      inc = sign ? {GRD_W{1'b1}} : '0;
         default:      inc = sign ? '0 : {GRD_W{1'b1}};
      endcase
   end

   assign at_edge_carry = (({1'b0, zsig} + (SIG_W+1)'(inc)) >= ((SIG_W+1)'(1) << (SIG_W - 1)));
   assign ovf  = (zexp > $signed(ZE_W'(OVF_E))) |
                 ((zexp == $signed(ZE_W'(OVF_E))) & at_edge_carry);
   assign tiny  = zexp[ZE_W-1];
   assign shamt = -zexp;

   always_comb begin
      if (shamt >= ZE_W'(SIG_W))
         jsig = {{(SIG_W-1){1'b0}}, |zsig};
      else
         jsig = (zsig >> shamt) |
                {{(SIG_W-1){1'b0}}, |(zsig & ~({SIG_W{1'b1}} << shamt))};
   end

   assign rsig  = tiny ? jsig : zsig;
   assign rexp  = tiny ? '0 : zexp[SEXP_W-1:0];
   assign rbits = rsig[GRD_W-1:0];

   always_comb begin
      m = M_W'(({1'b0, rsig} + (SIG_W+1)'(inc)) >> GRD_W);
      if ((mode == RM_NEAR_EVEN) && (rbits == HALF))
         m[0] = 1'b0;
      efin = (m == '0) ? '0 : rexp;
   end

   always_comb begin
      if (ovf) begin
         if (inc == '0)
            word = {sign, {(SEXP_W-1){1'b1}}, 1'b0, {SFRAC_W{1'b1}}};
         else
            word = {sign, {SEXP_W{1'b1}}, {SFRAC_W{1'b0}}};
         inx = 1'b1;
         unf = 1'b0;
      end else begin
         word = {sign, {(SW-1){1'b0}}} + {1'b0, efin, {SFRAC_W{1'b0}}} + SW'(m);
         inx  = (rbits != '0);
         unf  = tiny & (rbits != '0);
      end
   end
endmodule

// File: rtl/f64_to_f32_cvt.sv
`timescale 1ns/1ps
module f64_to_f32_cvt
   import f2s_pkg::*;
#(
   parameter int DEXP_W  = 11,
   parameter int DFRAC_W = 52,
   parameter int SEXP_W  = 8,
   parameter int SFRAC_W = 23,
   parameter int GRD_W   = 7
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          in_vld,
   input  logic [DEXP_W+DFRAC_W:0]       in_dbl,
   input  logic [1:0]                    rnd_mode,
   output logic                          out_vld,
   output logic [SEXP_W+SFRAC_W:0]       out_flt,
   output logic [3:0]                    out_flags
);
   localparam int SW    = 1 + SEXP_W + SFRAC_W;
   localparam int SIG_W = SFRAC_W + GRD_W + 2;
   localparam int ZE_W  = DEXP_W + 2;

   initial begin
      assert (GRD_W >= 2) else $error("guard width too small");
      assert (DFRAC_W >= SFRAC_W + GRD_W) else $error("source fraction narrower than working significand");
      assert (DEXP_W > SEXP_W) else $error("source exponent must be wider");
   end

   // stage one combinational
   logic                   u_sign, u_special, u_snan;
   logic [SW-1:0]          u_spword;
   logic signed [ZE_W-1:0] u_zexp;
   logic [SIG_W-1:0]       u_zsig;

   f2s_unpack #(
      .DEXP_W(DEXP_W), .DFRAC_W(DFRAC_W), .SEXP_W(SEXP_W),
      .SFRAC_W(SFRAC_W), .GRD_W(GRD_W)
   ) i_unpack (
      .in_word(in_dbl), .sign(u_sign), .is_special(u_special),
      .special_word(u_spword), .is_snan(u_snan),
      .zexp(u_zexp), .zsig(u_zsig)
   );

   // stage one registers
   logic                   s1_vld, s1_sign, s1_special, s1_snan;
   logic [SW-1:0]          s1_spword;
   logic signed [ZE_W-1:0] s1_zexp;
   logic [SIG_W-1:0]       s1_zsig;
   rmode_e                 s1_mode;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_vld <= 1'b0;
      end else begin
         s1_vld <= in_vld;
      end
      s1_sign    <= u_sign;
      s1_special <= u_special;
      s1_snan    <= u_snan;
      s1_spword  <= u_spword;
      s1_zexp    <= u_zexp;
      s1_zsig    <= u_zsig;
      s1_mode    <= rmode_e'(rnd_mode);
   end

   // stage two combinational
   logic [SW-1:0] r_word;
   logic          r_ovf, r_unf, r_inx;
   flags_t        nxt_flags;
   logic [SW-1:0] nxt_word;

   f2s_round #(
      .SEXP_W(SEXP_W), .SFRAC_W(SFRAC_W), .GRD_W(GRD_W), .ZE_W(ZE_W)
   ) i_round (
      .sign(s1_sign), .mode(s1_mode), .zexp(s1_zexp), .zsig(s1_zsig),
      .word(r_word), .ovf(r_ovf), .unf(r_unf), .inx(r_inx)
   );

   always_comb begin
      if (s1_special) begin
         nxt_word  = s1_spword;
         nxt_flags = '{invalid: s1_snan, overflow: 1'b0, underflow: 1'b0, inexact: 1'b0};
      end else begin
         nxt_word  = r_word;
         nxt_flags = '{invalid: 1'b0, overflow: r_ovf, underflow: r_unf, inexact: r_inx};
      end
   end

   // stage two registers
   always_ff @(posedge clk) begin
      if (rst) begin
         out_vld <= 1'b0;
      end else begin
         out_vld <= s1_vld;
      end
      out_flt   <= nxt_word;
      out_flags <= nxt_flags;
   end
endmodule

// File: rtl/f2s_cvt_chk.sv
`timescale 1ns/1ps
module f2s_cvt_chk (
   input logic        clk,
   input logic        rst,
   input logic        in_vld,
   input logic [1:0]  rnd_mode,
   input logic        out_vld,
   input logic [31:0] out_flt,
   input logic [3:0]  out_flags
);
   logic [1:0] since_rst;

   always_ff @(posedge clk) begin
      if (rst)
         since_rst <= 2'd0;
      else if (since_rst != 2'd3)
         since_rst <= since_rst + 2'd1;
   end

   // R10: valid stages empty on the first edge after reset
   p_rst_clear_r10: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 2'd0) |-> !out_vld);

   // R10: two-edge valid latency
   p_latency_r10: assert property (@(posedge clk) disable iff (rst)
      (since_rst >= 2'd2) |-> (out_vld == $past(in_vld, 2)));

   // R1: any NaN leaving the block is quiet
   p_nan_quiet_r1: assert property (@(posedge clk) disable iff (rst)
      (out_vld && (&out_flt[30:23]) && (|out_flt[22:0])) |-> out_flt[22]);

   // R2: invalid only accompanies a NaN and no other flag
   p_invalid_nan_r2: assert property (@(posedge clk) disable iff (rst)
      (out_vld && out_flags[3]) |->
         ((&out_flt[30:23]) && out_flt[22] && (out_flags[2:0] == 3'b000)));

   // R6: overflow implies inexact, never underflow
   p_overflow_inexact_r6: assert property (@(posedge clk) disable iff (rst)
      (out_vld && out_flags[2]) |-> (out_flags[0] && !out_flags[1]));

   // R7: underflow implies inexact
   p_underflow_inexact_r7: assert property (@(posedge clk) disable iff (rst)
      (out_vld && out_flags[1]) |-> out_flags[0]);

   // R5: toward-zero overflow saturates to the largest finite magnitude
   p_rtz_saturate_r5: assert property (@(posedge clk) disable iff (rst)
      ((since_rst >= 2'd2) && out_vld && out_flags[2] && ($past(rnd_mode, 2) == 2'd1))
         |-> (out_flt[30:0] == 31'h7F7FFFFF));
endmodule

bind f64_to_f32_cvt f2s_cvt_chk i_chk (
   .clk(clk), .rst(rst), .in_vld(in_vld), .rnd_mode(rnd_mode),
   .out_vld(out_vld), .out_flt(out_flt), .out_flags(out_flags)
);

// File: tb/test_f64_to_f32_cvt.sv
`timescale 1ns/1ps
module test_f64_to_f32_cvt;
   logic        clk = 1'b0;
   logic        rst;
   logic        in_vld;
   logic [63:0] in_dbl;
   logic [1:0]  rnd_mode;
   logic        out_vld;
   logic [31:0] out_flt;
   logic [3:0]  out_flags;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   f64_to_f32_cvt i_f64_to_f32_cvt (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_dbl(in_dbl),
      .rnd_mode(rnd_mode), .out_vld(out_vld), .out_flt(out_flt),
      .out_flags(out_flags)
   );

   // expectation pipeline: index 0 = driven last step, 1 = two steps ago
   logic        e_v [2];
   logic [31:0] e_r [2];
   logic [3:0]  e_f [2];
   string       e_t [2];

   function automatic void ref_cvt(input logic [63:0] d, input logic [1:0] m,
                                   output logic [31:0] r, output logic [3:0] f);
      logic s;
      int ae, e, sh;
      logic [51:0] fr;
      longint unsigned mant, keep, rem, half, val, bits;
      logic up, away;
      s  = d[63];
      ae = int'(d[62:52]);
      fr = d[51:0];
      f  = 4'b0000;
      away = ((m == 2'd2) && s) || ((m == 2'd3) && !s);
      if (ae == 2047) begin
         if (fr != 0) begin
            r = {s, 8'hFF, 1'b1, fr[50:29]};
            f[3] = !fr[51];
         end else
            r = {s, 8'hFF, 23'd0};
         return;
      end
      if (ae == 0) begin
         if (fr == 0) r = {s, 31'd0};
         else begin
            r = {s, 30'd0, away};
            f = 4'b0011;
         end
         return;
      end
      mant = {11'd0, 1'b1, fr};
      e = ae - 896;
      sh = (e >= 1) ? 29 : 30 - e;
      if (sh > 63) begin
         keep = 0; rem = 1; half = 64'h8000_0000_0000_0000;
      end else begin
         keep = mant >> sh;
         rem  = mant & ((64'd1 << sh) - 64'd1);
         half = 64'd1 << (sh - 1);
      end
      case (m)
         2'd0:    up = (rem > half) || ((rem == half) && keep[0]);
         2'd1:    up = 1'b0;
         default: up = away && (rem != 0);
      endcase
      val  = keep + {63'd0, up};
      f[0] = (rem != 0);
      if (e >= 1) begin
         bits = (longint'(e - 1) << 23) + val;
         if (bits >= (64'd255 << 23)) begin
            r = ((m == 2'd0) || away) ? {s, 8'hFF, 23'd0} : {s, 8'hFE, 23'h7FFFFF};
            f = 4'b0101;
            return;
         end
         r = {s, bits[30:0]};
      end else begin
         r = {s, val[30:0]};
         f[1] = (rem != 0);
      end
   endfunction

   function automatic string tag_of(input logic [63:0] d, input logic [1:0] m,
                                    input logic [3:0] f);
      if (d[62:52] == 11'h7FF) begin
         if (d[51:0] == 0) return "R3";
         return f[3] ? "R2" : "R1";
      end
      if (d[62:52] == 0) return "R8";
      if (f[2]) return "R6";
      if (f[1] || (d[62:52] < 11'h381)) return "R7";
      if (m != 2'd0) return "R5";
      if (f[0]) return "R9";
      return "R4";
   endfunction

   task automatic check_out();
      n_chk++;
      if (out_vld !== e_v[1]) begin
         n_bad++;
         $display("FAIL R10 out_vld actual %0b expected %0b", out_vld, e_v[1]);
      end else if (e_v[1]) begin
         if ((out_flt !== e_r[1]) || (out_flags !== e_f[1])) begin
            n_bad++;
            $display("FAIL %s result actual %h/%b expected %h/%b",
                     e_t[1], out_flt, out_flags, e_r[1], e_f[1]);
         end
      end
   endtask

   task automatic step(input logic v, input logic [63:0] d, input logic [1:0] m,
                       input string tag);
      logic [31:0] r;
      logic [3:0]  f;
      @(negedge clk);
      check_out();
      ref_cvt(d, m, r, f);
      e_v[1] = e_v[0]; e_r[1] = e_r[0]; e_f[1] = e_f[0]; e_t[1] = e_t[0];
      e_v[0] = v; e_r[0] = r; e_f[0] = f;
      e_t[0] = (tag == "") ? tag_of(d, m, f) : tag;
      in_vld = v; in_dbl = d; rnd_mode = m;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL R10 watchdog expired");
      finish_run();
   end

   initial begin
      logic [63:0] d;
      int sel;
      void'($urandom(32'h5EED_0042));
      rst = 1'b1; in_vld = 1'b0; in_dbl = '0; rnd_mode = 2'd0;
      for (int i = 0; i < 2; i++) begin
         e_v[i] = 1'b0; e_r[i] = '0; e_f[i] = '0; e_t[i] = "R10";
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_chk++;
      if (out_vld !== 1'b0) begin
         n_bad++;
         $display("FAIL R10 reset out_vld actual %0b expected 0", out_vld);
      end
      rst = 1'b0;

      // directed corners
      step(1, 64'h3FF0_0000_0000_0000, 2'd0, "R9");  // 1.0 exact, no inexact
      step(1, 64'h3FF0_0000_1000_0000, 2'd0, "R4");  // exact tie, keep even
      step(1, 64'h3FF0_0000_3000_0000, 2'd0, "R4");  // tie with odd keep, rounds up
      step(1, 64'h3FF0_0000_0000_0001, 2'd0, "R9");  // lone low bit -> inexact
      step(1, 64'h3FF0_0000_0000_0001, 2'd3, "R5");  // up mode bumps
      step(1, 64'hBFF0_0000_0000_0001, 2'd2, "R5");  // down mode, negative bumps
      step(1, 64'hBFF0_0000_0000_0001, 2'd1, "R5");  // toward zero truncates
      step(1, 64'h7FEF_FFFF_FFFF_FFFF, 2'd0, "R6");  // max double -> inf
      step(1, 64'h7FEF_FFFF_FFFF_FFFF, 2'd1, "R6");  // -> max finite
      step(1, 64'hFFEF_FFFF_FFFF_FFFF, 2'd3, "R6");  // negative, up -> -max finite
      step(1, 64'h47EF_FFFF_F000_0000, 2'd0, "R6");  // tie at top edge -> inf
      step(1, 64'h47EF_FFFF_E000_0000, 2'd0, "R4");  // exactly max finite
      step(1, 64'h36A0_0000_0000_0000, 2'd0, "R7");  // smallest subnormal, exact
      step(1, 64'h3690_0000_0000_0000, 2'd0, "R7");  // half of it, tie -> 0
      step(1, 64'h3690_0000_0000_0000, 2'd3, "R7");  // up -> smallest subnormal
      step(1, 64'h0000_0000_0000_0000, 2'd0, "R8");
      step(1, 64'h8000_0000_0000_0000, 2'd3, "R8");
      step(1, 64'h0000_0000_0000_0001, 2'd3, "R8");
      step(1, 64'h8000_0000_0000_0001, 2'd0, "R8");
      step(1, 64'h7FF0_0000_0000_0000, 2'd0, "R3");
      step(1, 64'hFFF0_0000_0000_0000, 2'd2, "R3");
      step(1, 64'h7FF8_0000_0000_0001, 2'd0, "R1");  // quiet NaN, low payload lost
      step(1, 64'hFFF5_5555_5555_5555, 2'd0, "R1");
      step(1, 64'h7FF0_0000_0000_0001, 2'd1, "R2");  // signaling NaN
      step(0, 64'h3FF0_0000_0000_0000, 2'd0, "R10"); // bubble

      // reset with operands in flight
      step(1, 64'h4000_0000_0000_0000, 2'd0, "R10");
      step(1, 64'h4008_0000_0000_0000, 2'd0, "R10");
      @(negedge clk);
      in_vld = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      n_chk++;
      if (out_vld !== 1'b0) begin
         n_bad++;
         $display("FAIL R10 mid-run reset out_vld actual %0b expected 0", out_vld);
      end
      rst = 1'b0;
      for (int i = 0; i < 2; i++) e_v[i] = 1'b0;

      // constrained random
      for (int n = 0; n < 4000; n++) begin
         d = {$urandom, $urandom};
         sel = int'($urandom % 8);
         case (sel)
            1, 2: d[62:52] = 11'(32'h360 + ($urandom % 40));
            3:    d[62:52] = 11'(32'h47D + ($urandom % 3));
            4:    d[62:52] = 11'h000;
            5:    d[62:52] = 11'h7FF;
            6:    begin
                     d[62:52] = 11'(32'h370 + ($urandom % 256));
                     d[28:0]  = ($urandom % 2) ? 29'h1000_0000 : 29'h0;
                  end
            7:    begin
                     d[62:52] = 11'(32'h37E + ($urandom % 260));
                     d[51:29] = 23'h7FFFFF;
                  end
            default: ;
         endcase
         step(($urandom % 8) != 0, d, 2'($urandom % 4), "");
      end
      step(0, '0, 2'd0, "R10");
      step(0, '0, 2'd0, "R10");
      step(0, '0, 2'd0, "R10");
      finish_run();
   end
endmodule